// File: doc/BRIEF.md
# Coherent Time Register Buffer

This block sits between a byte-wide serial register port and a set of running time counters (seconds, minutes, hours, day-of-week, date, month, year, century). It holds one shadow byte per counter. When a bus transaction opens, all shadow bytes take the counters' present value in the same cycle. They then stay frozen until the transaction closes, so a multi-byte read sees one instant in time. Host writes land in the shadow bytes. When the transaction closes, the whole shadow set is handed to the counters in a single load pulse, provided a time byte was written.

A control register carries a hold bit. The hold bit is set at reset and by a power-fail strobe, which also captures the time of failure. While the bit is set, the shadow bytes ignore the counters, so software can read the time of failure after power returns. Clearing the bit brings back live tracking. The counter arithmetic and the bus protocol engine are outside the block. The protocol engine is seen as open, close, pointer-load and byte strobes. The counters are seen as a value bus, an update strobe and a load pulse.

Top module: `time_shadow_regs`

## Requirements
- R1: After reset the hold bit (bit 7 of the control register at address 8) is 1, the pointer is 0, every shadow byte and every storage register is 0, and `cnt_load` is low.
- R2: With the hold bit clear, `xfer_start` copies `cnt_now` into all shadow bytes at that clock edge. Shadow byte k is bits 8k+7:8k of `cnt_now` and `cnt_wdata`, at register address k.
- R3: Between `xfer_start` and `xfer_stop`, a `cnt_tick` leaves the shadow bytes unchanged.
- R4: Outside a transaction, with the hold bit clear, a `cnt_tick` loads `cnt_now` into the shadow bytes, visible on the next cycle.
- R5: `ptr_load` sets the pointer. Each `byte_rd` or `byte_wr` advances it by one, wrapping from 15 to 0. `byte_rdata` shows the register at the pointer with no added latency.
- R6: A write to addresses 0 to 7 sets a write flag. At `xfer_stop` with the flag set, `cnt_load` is high for exactly the next cycle. During that cycle `cnt_wdata` carries all eight shadow bytes, including the ones not written.
- R7: The write flag is cleared at `xfer_stop`, and writes to addresses 8 to 15 do not set it. A transaction with no time-byte write gives no `cnt_load`.
- R8: `pwr_fail` copies `cnt_now` into the shadow bytes and sets the hold bit.
- R9: While the hold bit is set, neither `xfer_start` nor `cnt_tick` changes the shadow bytes.
- R10: Writing a byte with bit 7 equal to 0 to address 8 clears the hold bit. A later `xfer_start` then captures the present `cnt_now`.
- R11: A time-byte write while the hold bit is set loads the captured time, with only the written bytes replaced, into the counters.
- R12: A `cnt_tick` in the same cycle as `cnt_load` does not alter the shadow bytes.
- R13: Bits 6:0 of address 8 and addresses 9 to 15 are plain storage that read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transaction opens (one-cycle strobe) |
| xfer_stop | input | 1 | Transaction closes (one-cycle strobe) |
| ptr_load | input | 1 | Load the register pointer from `ptr_val` |
| ptr_val | input | 4 | New pointer value |
| byte_wr | input | 1 | Write `byte_wdata` at the pointer, then advance |
| byte_wdata | input | 8 | Write data |
| byte_rd | input | 1 | Byte consumed by a read; advance the pointer |
| byte_rdata | output | 8 | Register at the pointer |
| cnt_tick | input | 1 | Counters took a new value this cycle |
| cnt_now | input | 64 | Present counter values, byte k = counter k |
| pwr_fail | input | 1 | Power-fail strobe: capture the time and set hold |
| cnt_load | output | 1 | Load the counters from `cnt_wdata` |
| cnt_wdata | output | 64 | Shadow bytes, byte k = address k |

## Verification
All state changes take effect at the clock edge where the strobe is high. The shadow bytes, the hold bit and `cnt_load` therefore show a stimulus one cycle later. `byte_rdata` follows the pointer combinationally, so it is due in the cycle after a `ptr_load`. The bench drives each strobe just after a falling edge and drops it at the next falling edge. It checks at that falling edge, which is the first stable point after the rising edge that acted. The one-cycle width of `cnt_load` is checked one more falling edge later.

// File: rtl/time_shadow_regs.sv
module time_shadow_regs #(
  parameter int NCLK   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_stop,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              byte_wr,
  input  logic [7:0]        byte_wdata,
  input  logic              byte_rd,
  output logic [7:0]        byte_rdata,
  input  logic              cnt_tick,
  input  logic [8*NCLK-1:0] cnt_now,
  input  logic              pwr_fail,
  output logic              cnt_load,
  output logic [8*NCLK-1:0] cnt_wdata
);
  localparam int NREG  = 2 ** ADDR_W;
  localparam int NUSR  = NREG - NCLK;
  localparam int CAW   = $clog2(NCLK);
  localparam int UAW   = $clog2(NUSR);
  localparam logic [ADDR_W-1:0] CTRL = ADDR_W'(NCLK);

  logic [NCLK-1:0][7:0] tbuf;
  logic [7:0]           ureg [NUSR];
  logic [ADDR_W-1:0]    ptr;
  logic                 halt, wflag, in_xfer;

  wire              is_clk = (ptr < CTRL);
  wire [CAW-1:0]    cidx   = ptr[CAW-1:0];
  wire [UAW-1:0]    uidx   = UAW'(ptr - CTRL);
  wire              track  = !halt && !in_xfer && cnt_tick && !cnt_load;
  wire              snap   = !halt && xfer_start;

  assign cnt_wdata = tbuf;

  always_comb begin
    if (is_clk)          byte_rdata = tbuf[cidx];
    else if (ptr == CTRL) byte_rdata = {halt, ureg[0][6:0]};
    else                 byte_rdata = ureg[uidx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      halt     <= 1'b1;
      wflag    <= 1'b0;
      in_xfer  <= 1'b0;
      cnt_load <= 1'b0;
    end else begin
      if (ptr_load)               ptr <= ptr_val;
      else if (byte_wr || byte_rd) ptr <= ptr + 1'b1;
      if (pwr_fail)                         halt <= 1'b1;
      else if (byte_wr && ptr == CTRL)      halt <= byte_wdata[7];
      if (xfer_stop)                        wflag <= 1'b0;
      else if (byte_wr && is_clk)           wflag <= 1'b1;
      if (xfer_start)      in_xfer <= 1'b1;
      else if (xfer_stop)  in_xfer <= 1'b0;
      cnt_load <= xfer_stop && wflag;
    end
  end

  for (genvar u = 0; u < NUSR; u++) begin : g_usr
    always_ff @(posedge clk) begin
      if (!rst_n) ureg[u] <= '0;
      else if (byte_wr && !is_clk && uidx == UAW'(u)) ureg[u] <= byte_wdata;
    end
  end

  for (genvar k = 0; k < NCLK; k++) begin : g_clk
    always_ff @(posedge clk) begin
      if (!rst_n)                                  tbuf[k] <= '0;
      else if (pwr_fail)                           tbuf[k] <= cnt_now[8*k +: 8];
      else if (byte_wr && is_clk && cidx == CAW'(k)) tbuf[k] <= byte_wdata;
      else if (snap || track)                      tbuf[k] <= cnt_now[8*k +: 8];
    end
  end

  assert_snapshot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !halt && !pwr_fail && !byte_wr) |=> (cnt_wdata == $past(cnt_now)));
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !xfer_start && !byte_wr && !pwr_fail) |=> $stable(cnt_wdata));
  assert_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !in_xfer && cnt_tick && !cnt_load && !xfer_start && !byte_wr && !pwr_fail)
    |=> (cnt_wdata == $past(cnt_now)));
  assert_load_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> $past(xfer_stop));
  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);
  assert_flag_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr && !is_clk && !wflag && !xfer_stop) |=> !wflag);
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (halt && cnt_wdata == $past(cnt_now)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !byte_wr && !pwr_fail) |=> $stable(cnt_wdata));
  assert_copy_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !xfer_start && !byte_wr && !pwr_fail) |=> $stable(cnt_wdata));
endmodule

// File: tb/time_shadow_regs_tb_top.sv
module time_shadow_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 0, xfer_stop = 0, ptr_load = 0, byte_wr = 0, byte_rd = 0;
  logic        cnt_tick = 0, pwr_fail = 0;
  logic [3:0]  ptr_val = '0;
  logic [7:0]  byte_wdata = '0;
  logic [63:0] cnt_now = '0;
  logic [7:0]  byte_rdata;
  logic        cnt_load;
  logic [63:0] cnt_wdata;
  int checks = 0, errors = 0;
  logic load_seen;
  logic [63:0] exp_t;

  always #4 clk = ~clk;

  time_shadow_regs dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .byte_wr(byte_wr), .byte_wdata(byte_wdata),
    .byte_rd(byte_rd), .byte_rdata(byte_rdata), .cnt_tick(cnt_tick), .cnt_now(cnt_now),
    .pwr_fail(pwr_fail), .cnt_load(cnt_load), .cnt_wdata(cnt_wdata));

  localparam logic [63:0] T1 = 64'h2001_0403_0223_5958, T2 = 64'h2024_1231_0723_5959;
  localparam logic [63:0] T3 = 64'h2030_0615_0312_3045, T4 = 64'h2030_0615_0312_3046;
  localparam logic [63:0] T5 = 64'h2030_0615_0312_3047, T6 = 64'h2008_0309_0119_2344;
  localparam logic [63:0] T7 = 64'h2008_0309_0119_2345, T8 = 64'h2008_0310_0208_1500;

  // {address, data, load expected}
  localparam logic [12:0] VEC [0:6] = '{
    {4'h9, 8'h3C, 1'b0}, {4'hF, 8'hA5, 1'b0}, {4'h3, 8'h11, 1'b1},
    {4'h8, 8'h15, 1'b0}, {4'h7, 8'h20, 1'b1}, {4'hB, 8'h7E, 1'b0},
    {4'h0, 8'h59, 1'b1}};

  function automatic logic [63:0] put_byte(logic [63:0] t, int idx, logic [7:0] b);
    logic [63:0] r = t;
    r[8*idx +: 8] = b;
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start_x();
    xfer_start = 1; @(negedge clk); xfer_start = 0;
  endtask
  task automatic stop_x();
    xfer_stop = 1; @(negedge clk); xfer_stop = 0; load_seen = cnt_load;
  endtask
  task automatic set_ptr(input logic [3:0] a);
    ptr_val = a; ptr_load = 1; @(negedge clk); ptr_load = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    byte_wdata = d; byte_wr = 1; @(negedge clk); byte_wr = 0;
  endtask
  task automatic rd(output logic [7:0] d);
    d = byte_rdata; byte_rd = 1; @(negedge clk); byte_rd = 0;
  endtask
  task automatic tick(input logic [63:0] t);
    cnt_now = t; cnt_tick = 1; @(negedge clk); cnt_tick = 0;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(byte_rdata == 8'h00, "R1 shadow byte 0", {56'h0, byte_rdata}, 64'h0);
    chk(cnt_wdata == 64'h0, "R1 shadow bytes", cnt_wdata, 64'h0);
    chk(cnt_load == 1'b0, "R1 load low", {63'h0, cnt_load}, 64'h0);
    set_ptr(4'h8);
    chk(byte_rdata == 8'h80, "R1 hold bit set", {56'h0, byte_rdata}, 64'h80);
    // R9 hold set: no tracking, no snapshot
    tick(T1);
    chk(cnt_wdata == 64'h0, "R9 tick under hold", cnt_wdata, 64'h0);
    start_x();
    chk(cnt_wdata == 64'h0, "R9 start under hold", cnt_wdata, 64'h0);
    stop_x();
    // R10 clear hold
    start_x(); set_ptr(4'h8); wr(8'h00); stop_x();
    chk(load_seen == 1'b0, "R7 control write no load", {63'h0, load_seen}, 64'h0);
    set_ptr(4'h8);
    chk(byte_rdata == 8'h00, "R10 hold cleared", {56'h0, byte_rdata}, 64'h0);
    // R4 tracking
    tick(T2);
    chk(cnt_wdata == T2, "R4 tracking", cnt_wdata, T2);
    // Vector table: R6 / R7 / R13
    for (int i = 0; i < 7; i++) begin
      start_x(); set_ptr(VEC[i][12:9]); wr(VEC[i][8:1]); stop_x();
      chk(load_seen == VEC[i][0], "R6 R7 load per address", {63'h0, load_seen}, {63'h0, VEC[i][0]});
      @(negedge clk);
      chk(cnt_load == 1'b0, "R6 load one cycle", {63'h0, cnt_load}, 64'h0);
      set_ptr(VEC[i][12:9]);
      chk(byte_rdata == VEC[i][8:1], "R13 readback", {56'h0, byte_rdata}, {56'h0, VEC[i][8:1]});
    end
    // R5 auto-increment and wrap
    start_x(); set_ptr(4'hF); wr(8'hC3); wr(8'h44); stop_x();
    chk(load_seen == 1'b1, "R5 wrap wrote address 0", {63'h0, load_seen}, 64'h1);
    chk(cnt_wdata[7:0] == 8'h44, "R5 wrapped byte", {56'h0, cnt_wdata[7:0]}, 64'h44);
    set_ptr(4'hF); rd(b);
    chk(b == 8'hC3, "R5 read at 15", {56'h0, b}, 64'hC3);
    chk(byte_rdata == 8'h44, "R5 pointer wrapped to 0", {56'h0, byte_rdata}, 64'h44);
    // R2 snapshot, R3 freeze
    cnt_now = T3; start_x();
    chk(cnt_wdata == T3, "R2 snapshot", cnt_wdata, T3);
    tick(T4);
    chk(cnt_wdata == T3, "R3 frozen in transaction", cnt_wdata, T3);
    stop_x();
    chk(load_seen == 1'b0, "R7 flag cleared at stop", {63'h0, load_seen}, 64'h0);
    tick(T4);
    chk(cnt_wdata == T4, "R4 tracking resumes", cnt_wdata, T4);
    // R6 full copy
    start_x(); set_ptr(4'h2); wr(8'h99); stop_x();
    exp_t = put_byte(T4, 2, 8'h99);
    chk(load_seen == 1'b1, "R6 load pulse", {63'h0, load_seen}, 64'h1);
    chk(cnt_wdata == exp_t, "R6 all bytes copied", cnt_wdata, exp_t);
    // R12 tick during the load cycle
    start_x(); set_ptr(4'h1); wr(8'h42); stop_x();
    exp_t = put_byte(T4, 1, 8'h42);
    tick(T5);
    chk(cnt_wdata == exp_t, "R12 copy beats tick", cnt_wdata, exp_t);
    // R8 power fail
    cnt_now = T6; pwr_fail = 1; @(negedge clk); pwr_fail = 0;
    chk(cnt_wdata == T6, "R8 capture", cnt_wdata, T6);
    set_ptr(4'h8);
    chk(byte_rdata == 8'h95, "R8 hold set", {56'h0, byte_rdata}, 64'h95);
    tick(T7);
    chk(cnt_wdata == T6, "R9 held time", cnt_wdata, T6);
    // R11 write under hold
    start_x(); set_ptr(4'h5); wr(8'h0A); stop_x();
    exp_t = put_byte(T6, 5, 8'h0A);
    chk(load_seen == 1'b1, "R11 load", {63'h0, load_seen}, 64'h1);
    chk(cnt_wdata == exp_t, "R11 stale time loaded", cnt_wdata, exp_t);
    // R10 clear hold then present time
    start_x(); set_ptr(4'h8); wr(8'h15); stop_x();
    cnt_now = T8; start_x();
    chk(cnt_wdata == T8, "R10 present time after clear", cnt_wdata, T8);
    stop_x();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule